// File: doc/BRIEF.md
# Forwarding FIFO Store Buffer

This block is the private store buffer of one hardware thread. Every store the thread issues lands in a first-in first-out queue, never in shared memory directly. The oldest queued store is offered on a drain port, and it leaves the queue on the cycle that the memory side accepts it. A load from the thread first searches every queued store by address. When one or more entries match, the youngest one answers in the same cycle. When none matches, the load goes out on a memory read port and completes when memory returns data.

A fence request completes only once the queue has fully drained. This lets the thread order its later loads after all of its earlier stores. An empty flag is exported so that surrounding logic, for example the logic that holds a global lock for atomic operations, can wait for the buffer to flush. Stores are accepted whenever there is room, whatever any other thread is doing. Lock arbitration between threads is not part of this block.

Top module: `fwd_store_buffer`

## Requirements
- R1: An accepted write (`req_op` = 0) is stored in the buffer. It never raises `mem_rd_req`, and it reaches memory only through the drain port.
- R2: The drain port presents the oldest buffered entry. That entry is removed on a rising edge where `drn_valid` and `drn_ready` are both high. Entries leave in exactly the order they were written, and the head stays stable while `drn_ready` is low.
- R3: `drn_valid` is high exactly when the buffer holds at least one entry, and `sb_empty` is its complement.
- R4: A read (`req_op` = 1) whose address matches a buffered entry returns that entry's data with `rsp_valid` and `req_ready` high in the same cycle. It does not raise `mem_rd_req`.
- R5: When several buffered entries match the read address, the most recently written one supplies the data.
- R6: A read that matches no entry raises `mem_rd_req` with `mem_rd_addr` equal to the read address. It holds `rsp_valid` and `req_ready` low until `mem_rd_rvalid` is high, and then returns `mem_rd_rdata`.
- R7: A fence (`req_op` = 2) sees `req_ready` high only while the buffer is empty.
- R8: When all DEPTH entries are occupied, a write sees `req_ready` low and is not stored.
- R9: After reset the buffer is empty, and `drn_valid`, `rsp_valid` and `mem_rd_req` are low.
- R10: A write and a drain in the same cycle both take effect. The occupancy is unchanged and ordering is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Thread request present |
| req_op | input | 2 | 0 write, 1 read, 2 fence |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request completes this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DW | Read data |
| mem_rd_req | output | 1 | Read request to shared memory |
| mem_rd_addr | output | AW | Shared memory read address |
| mem_rd_rvalid | input | 1 | Shared memory read data valid |
| mem_rd_rdata | input | DW | Shared memory read data |
| drn_valid | output | 1 | Oldest entry offered to memory |
| drn_addr | output | AW | Oldest entry address |
| drn_data | output | DW | Oldest entry data |
| drn_ready | input | 1 | Memory accepts the oldest entry |
| sb_empty | output | 1 | Buffer holds no entries |

## Verification
Loads are tried against a buffer holding a single matching store, two stores to one address, and no matching store. These three cases separate same-cycle forwarding, youngest-first selection and the memory pass-through. Writes are issued with the drain stalled until the buffer fills, and then with the drain running back-to-back. The first pattern isolates the full stall and head stability. The second exercises simultaneous enqueue and dequeue, with a scoreboard checking drain order throughout. A fence is issued against a full buffer and held until it drains, which shows that its completion waits for the last entry.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_FENCE = 2'd2
  } sb_op_e;

  // physical slot holding the entry that is 'age' places behind the head
  function automatic int slot_of(int head, int age, int depth);
    return (head + age) % depth;
  endfunction

  // circular pointer advance
  function automatic int ptr_next(int ptr, int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // occupancy after one cycle of optional push and pop
  function automatic int occ_next(int occ, bit push, bit pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/sb_ring.sv
`timescale 1ns/1ps
module sb_ring #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [AW-1:0]               push_addr,
  input  logic [DW-1:0]               push_data,
  input  logic                        pop,
  output logic [PTR_W-1:0]            head_ptr,
  output logic [CNT_W-1:0]            count,
  output logic                        full,
  output logic                        empty,
  output logic [DEPTH-1:0][AW-1:0]    ent_addr,
  output logic [DEPTH-1:0][DW-1:0]    ent_data
);
  import sb_pkg::*;

  logic [PTR_W-1:0] tail_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      count    <= '0;
    end else begin
      if (push) tail_ptr <= PTR_W'(ptr_next(int'(tail_ptr), DEPTH));
      if (pop)  head_ptr <= PTR_W'(ptr_next(int'(head_ptr), DEPTH));
      count <= CNT_W'(occ_next(int'(count), push, pop));
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[tail_ptr] <= push_addr;
      ent_data[tail_ptr] <= push_data;
    end
  end

  assign full  = (int'(count) == DEPTH);
  assign empty = (count == '0);

endmodule

// File: rtl/sb_match.sv
`timescale 1ns/1ps
module sb_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic [PTR_W-1:0]         head_ptr,
  input  logic [CNT_W-1:0]         count,
  input  logic [AW-1:0]            look_addr,
  output logic                     hit,
  output logic [DW-1:0]            hit_data
);
  import sb_pkg::*;

  logic [PTR_W-1:0] slot;

  // scan from oldest to youngest; a later match overrides an earlier one
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    slot     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = PTR_W'(slot_of(int'(head_ptr), k, DEPTH));
      if (k < int'(count) && ent_addr[slot] == look_addr) begin
        hit      = 1'b1;
        hit_data = ent_data[slot];
      end
    end
  end

endmodule

// File: rtl/fwd_store_buffer.sv
`timescale 1ns/1ps
module fwd_store_buffer #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_rvalid,
  input  logic [DW-1:0] mem_rd_rdata,
  output logic          drn_valid,
  output logic [AW-1:0] drn_addr,
  output logic [DW-1:0] drn_data,
  input  logic          drn_ready,
  output logic          sb_empty
);
  import sb_pkg::*;

  // named internal events
  logic                     is_wr, is_rd, is_fence;
  logic                     wr_fire, pop;
  logic                     full, empty, hit;
  logic [DW-1:0]            hit_data;
  logic [PTR_W-1:0]         head_ptr;
  logic [CNT_W-1:0]         count;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;

  assign is_wr    = req_valid && (sb_op_e'(req_op) == OP_WRITE);
  assign is_rd    = req_valid && (sb_op_e'(req_op) == OP_READ);
  assign is_fence = req_valid && (sb_op_e'(req_op) == OP_FENCE);

  assign wr_fire  = is_wr && !full;
  assign pop      = !empty && drn_ready;

  sb_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_fire),
    .push_addr (req_addr),
    .push_data (req_wdata),
    .pop       (pop),
    .head_ptr  (head_ptr),
    .count     (count),
    .full      (full),
    .empty     (empty),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data)
  );

  sb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .head_ptr  (head_ptr),
    .count     (count),
    .look_addr (req_addr),
    .hit       (hit),
    .hit_data  (hit_data)
  );

  // drain port: the head entry
  assign drn_valid = !empty;
  assign drn_addr  = ent_addr[head_ptr];
  assign drn_data  = ent_data[head_ptr];
  assign sb_empty  = empty;

  // load path
  assign mem_rd_req  = is_rd && !hit;
  assign mem_rd_addr = req_addr;
  assign rsp_valid   = is_rd && (hit || mem_rd_rvalid);
  assign rsp_data    = hit ? hit_data : mem_rd_rdata;

  always_comb begin
    req_ready = 1'b0;
    if (is_wr)    req_ready = !full;
    if (is_rd)    req_ready = hit || mem_rd_rvalid;
    if (is_fence) req_ready = empty;
  end

endmodule

// File: rtl/sb_checker.sv
`timescale 1ns/1ps
module sb_checker #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             mem_rd_req,
  input logic             mem_rd_rvalid,
  input logic             drn_valid,
  input logic             drn_ready,
  input logic [AW-1:0]    drn_addr,
  input logic [DW-1:0]    drn_data,
  input logic             sb_empty,
  input logic [CNT_W-1:0] count,
  input logic             wr_fire,
  input logic             pop
);

  a_r1_write_lands_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !sb_empty);

  a_r1_write_no_mem_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0) |-> !mem_rd_req);

  a_r2_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (drn_valid && !drn_ready) |=> (drn_valid && $stable(drn_addr) && $stable(drn_data)));

  a_r6_miss_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_rvalid) |-> (!rsp_valid && !req_ready));

  a_r7_fence_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2 && req_ready) |-> (count == '0));

  a_r8_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && int'(count) == DEPTH) |-> !req_ready);

  a_r10_occupancy_step: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (count == CNT_W'($past(count) + CNT_W'($past(wr_fire)) - CNT_W'($past(pop)))));

endmodule

bind fwd_store_buffer sb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sb_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_op        (req_op),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .mem_rd_req    (mem_rd_req),
  .mem_rd_rvalid (mem_rd_rvalid),
  .drn_valid     (drn_valid),
  .drn_ready     (drn_ready),
  .drn_addr      (drn_addr),
  .drn_data      (drn_data),
  .sb_empty      (sb_empty),
  .count         (count),
  .wr_fire       (wr_fire),
  .pop           (pop)
);

// File: tb/fwd_store_buffer_tb_top.sv
`timescale 1ns/1ps
module fwd_store_buffer_tb_top;
  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int DW    = 32;

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, rsp_valid, mem_rd_req, drn_valid, sb_empty;
  logic [DW-1:0] rsp_data, drn_data;
  logic [AW-1:0] mem_rd_addr, drn_addr;
  logic          mem_rd_rvalid;
  logic [DW-1:0] mem_rd_rdata;
  logic          drn_ready;

  fwd_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_rvalid(mem_rd_rvalid),
    .mem_rd_rdata(mem_rd_rdata), .drn_valid(drn_valid), .drn_addr(drn_addr),
    .drn_data(drn_data), .drn_ready(drn_ready), .sb_empty(sb_empty)
  );

  int   n_chk = 0;
  int   n_bad = 0;
  ent_t expq[$];
  ent_t mon_e;

  function automatic logic [DW-1:0] mem_val(logic [AW-1:0] a);
    return {a, ~a} ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor: every drained entry must be the oldest expected one (R2, R1)
  always begin
    @(negedge clk);
    #2;
    if (rst_n && drn_valid && drn_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2 drain with nothing expected", {16'h0, drn_addr}, 64'h0);
      end else begin
        mon_e = expq.pop_front();
        check(drn_addr == mon_e.a && drn_data == mon_e.d, "R2 R1 drain order",
              {16'h0, drn_addr, drn_data}, {16'h0, mon_e.a, mon_e.d});
      end
    end
  end

  task automatic idle_req();
    req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_wdata = '0;
  endtask

  // driver: issue a write, push the expected entry when it is accepted
  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    ent_t e;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    check(!mem_rd_req, "R1 write raises no memory read", 64'(mem_rd_req), 64'h0);
    e.a = a; e.d = d;
    expq.push_back(e);
    @(posedge clk);
    #0.5;
    idle_req();
  endtask

  // read: expected result from the bench's own copy of the buffer
  task automatic do_read(logic [AW-1:0] a, string req);
    bit            found = 1'b0;
    logic [DW-1:0] exp_d = '0;
    for (int i = 0; i < expq.size(); i++)
      if (expq[i].a == a) begin found = 1'b1; exp_d = expq[i].d; end
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = a;
    #1;
    if (found) begin
      check(rsp_valid && req_ready && !mem_rd_req, {req, " forward handshake"},
            {61'h0, rsp_valid, req_ready, mem_rd_req}, 64'h6);
      check(rsp_data == exp_d, {req, " forward data"}, 64'(rsp_data), 64'(exp_d));
    end else begin
      check(mem_rd_req && mem_rd_addr == a && !rsp_valid && !req_ready,
            {req, " miss request"}, {mem_rd_req, rsp_valid, req_ready, 13'h0, mem_rd_addr},
            {3'b100, 13'h0, a});
      @(negedge clk);
      #1;
      check(!rsp_valid && !req_ready, {req, " miss still waiting"},
            {62'h0, rsp_valid, req_ready}, 64'h0);
      @(negedge clk);
      mem_rd_rvalid = 1'b1; mem_rd_rdata = mem_val(a);
      #1;
      check(rsp_valid && req_ready && rsp_data == mem_val(a), {req, " miss data"},
            {rsp_valid, req_ready, 30'h0, rsp_data}, {2'b11, 30'h0, mem_val(a)});
    end
    @(posedge clk);
    #0.5;
    idle_req();
    mem_rd_rvalid = 1'b0; mem_rd_rdata = '0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; drn_ready = 1'b0; mem_rd_rvalid = 1'b0; mem_rd_rdata = '0;
    idle_req();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: reset state
    check(sb_empty && !drn_valid && !rsp_valid && !mem_rd_req, "R9 reset state",
          {60'h0, sb_empty, drn_valid, rsp_valid, mem_rd_req}, 64'h8);

    // writes with the drain stalled
    do_write(16'h0010, 32'hAAAA_0001);
    do_write(16'h0020, 32'hBBBB_0002);
    do_write(16'h0010, 32'hCCCC_0003);
    @(negedge clk); #1;
    check(drn_valid && !sb_empty, "R3 not empty after writes",
          {62'h0, drn_valid, sb_empty}, 64'h2);
    check(drn_addr == 16'h0010 && drn_data == 32'hAAAA_0001, "R2 head is oldest",
          {16'h0, drn_addr, drn_data}, {32'h0010, 32'hAAAA_0001});

    do_read(16'h0010, "R5 youngest of two matches");
    do_read(16'h0020, "R4 single match");
    do_read(16'h0030, "R6 no match");

    // fill to capacity
    for (int i = 0; i < DEPTH - 3; i++) do_write(16'h0100 + 16'(i), 32'hD000_0000 + 32'(i));
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = 16'h0FFF; req_wdata = 32'hDEAD_BEEF;
    for (int i = 0; i < 3; i++) begin
      #1;
      check(!req_ready, "R8 full blocks write", 64'(req_ready), 64'h0);
      @(negedge clk);
    end
    idle_req();

    // fence against a full buffer, then let it drain
    req_valid = 1'b1; req_op = 2'd2;
    for (int i = 0; i < 2; i++) begin
      #1;
      check(!req_ready, "R7 fence stalls while buffer holds stores", 64'(req_ready), 64'h0);
      @(negedge clk);
    end
    @(posedge clk); #0.5;
    drn_ready = 1'b1;
    begin
      int waited = 0;
      @(negedge clk); #1;
      while (!req_ready && waited < 100) begin
        @(negedge clk); #1;
        waited++;
      end
      check(req_ready && sb_empty && expq.size() == 0, "R7 fence completes once drained",
            {61'h0, req_ready, sb_empty, expq.size() == 0}, 64'h7);
    end
    @(posedge clk); #0.5;
    idle_req();

    // back-to-back writes while the drain is running
    for (int i = 0; i < 6; i++) do_write(16'h0200 + 16'(i), 32'hE000_0000 + 32'(i));
    begin
      int waited = 0;
      while (expq.size() != 0 && waited < 100) begin
        @(negedge clk);
        waited++;
      end
    end
    @(negedge clk); #1;
    check(sb_empty && !drn_valid && expq.size() == 0, "R10 write with drain keeps order and count",
          {61'h0, sb_empty, drn_valid, expq.size() == 0}, 64'h5);

    // stalled burst, then a drain with toggling ready
    @(posedge clk); #0.5;
    drn_ready = 1'b0;
    for (int i = 0; i < 4; i++) do_write(16'h0300 + 16'(i % 2), 32'hF000_0000 + 32'(i));
    do_read(16'h0301, "R5 youngest match after interleaved writes");
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #0.5;
      drn_ready = ~drn_ready;
    end
    @(posedge clk); #0.5;
    drn_ready = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    check(sb_empty && expq.size() == 0, "R2 all entries drained",
          {62'h0, sb_empty, expq.size() == 0}, 64'h3);

    // stores left only through the drain port; now the read misses
    do_read(16'h0010, "R1 R6 drained address goes to memory");

    summary();
    $finish;
  end

endmodule